// File: doc/BRIEF.md
# Address-Range Mirroring Read Error Handler

This block sits between a memory controller's read path and its error reporting logic. Software programs a node base address, a mirror enable and a mirror span. The span is counted in coarse granules of 2^GRAN_SHIFT bytes, which is 64 MB by default. Each read is first classified as inside or outside the mirrored window. The primary copy is then fetched. When the primary copy comes back with an uncorrectable ECC result inside the window, and redundancy is still intact, the block fetches the secondary copy and returns that data. In that case the event is reported only as a corrected error.

Uncorrectable results outside the window raise a fatal machine-check pulse and a poisoned response. If the secondary copy also fails, the result is the same. While scrubbing is enabled, uncorrectable errors inside the window are counted. When a programmable count is reached, the block declares failover and stays in independent mode until reset. From then on, uncorrectable errors in the former window are fatal.

Writes pass straight through to the primary copy. While the window is still redundant, writes that land in it are duplicated to the secondary copy. The block also reports the usable memory size in granules. That size excludes the hidden secondary copy.

Top module: `mirr_err_handler`

## Requirements
- R1: An address is mirrored exactly when cfg_mirror_en is 1 and cfg_node_base <= addr < cfg_node_base + (cfg_mirror_field + 1) * 2^GRAN_SHIFT. With base 0 and field 0x0F, 0x3FFF_FFFE and 0x3FFF_FFFF are inside and 0x4000_0000 is outside.
- R2: A read whose primary response has mem_rsp_uce = 0 returns the primary data with rsp_poison = 0 and rsp_from_sec = 0. It raises no ce_pulse, no mce_pulse and no secondary read.
- R3: A primary uncorrectable error on a mirrored address before failover causes exactly one secondary read (mem_req_sec = 1). If that read is clean, the secondary data is returned with rsp_from_sec = 1 and rsp_poison = 0, with one ce_pulse and no mce_pulse.
- R4: A primary uncorrectable error on an unmirrored address gives one mce_pulse and rsp_poison = 1, with no secondary read and no ce_pulse.
- R5: If the secondary copy also returns an uncorrectable error, the response carries rsp_poison = 1 and rsp_from_sec = 1, with one mce_pulse and no ce_pulse. ce_pulse and mce_pulse are never high in the same cycle.
- R6: While cfg_scrub_en is 1, each primary uncorrectable error in the window counts. When the count reaches cfg_fail_thresh (0 treated as 1), failover_pulse fires once and failover_state rises. failover_state stays high until reset. The triggering read is still recovered from the secondary copy and reported as corrected.
- R7: While cfg_scrub_en is 0, failover is never declared and errors do not count toward the threshold.
- R8: After failover, a primary uncorrectable error on a formerly mirrored address is handled as in R4.
- R9: A write always drives mem_wr_pri_valid with its address and data unchanged. mem_wr_sec_valid is added only when the write address is mirrored and failover_state is 0.
- R10: usable_size equals cfg_total_gran - (cfg_mirror_field + 1) when mirroring is enabled, floored at 0. It equals cfg_total_gran when mirroring is disabled.
- R11: After reset, rd_ready = 1, rsp_valid = 0, mem_req_valid = 0, all pulses are 0 and failover_state = 0. A memory request is only issued while rd_ready is 0.
- R12: rsp_valid, rsp_data and rsp_poison hold steady until rsp_ready is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mirror_en | input | 1 | Enables the mirrored window |
| cfg_node_base | input | ADDR_W | Node base address |
| cfg_mirror_field | input | FIELD_W | Mirror span minus one, in granules |
| cfg_scrub_en | input | 1 | Enables error counting and failover |
| cfg_fail_thresh | input | CNT_W | Error count that declares failover |
| cfg_total_gran | input | ADDR_W-GRAN_SHIFT+1 | Installed memory in granules |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted |
| rd_addr | input | ADDR_W | Read address |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response taken |
| rsp_data | output | DATA_W | Read response data |
| rsp_poison | output | 1 | Response data is uncorrectable |
| rsp_from_sec | output | 1 | Response came from the secondary copy |
| mem_req_valid | output | 1 | One-cycle memory read request |
| mem_req_addr | output | ADDR_W | Memory read address |
| mem_req_sec | output | 1 | Request targets the secondary copy |
| mem_rsp_valid | input | 1 | Memory read response valid |
| mem_rsp_uce | input | 1 | Response has an uncorrectable ECC result |
| mem_rsp_data | input | DATA_W | Memory read data |
| wr_valid | input | 1 | Write valid |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| mem_wr_pri_valid | output | 1 | Write to primary copy |
| mem_wr_sec_valid | output | 1 | Write to secondary copy |
| mem_wr_addr | output | ADDR_W | Write address to memory |
| mem_wr_data | output | DATA_W | Write data to memory |
| ce_pulse | output | 1 | Corrected-error event |
| mce_pulse | output | 1 | Fatal machine-check event |
| failover_pulse | output | 1 | Failover declared |
| failover_state | output | 1 | Redundancy lost, independent mode |
| usable_size | output | ADDR_W-GRAN_SHIFT+1 | Usable memory in granules |

## Verification
The bench builds the block with ADDR_W = 36, GRAN_SHIFT = 26 (64 MB granules), FIELD_W = 8, CNT_W = 4, DATA_W = 64 and a registered size output. The failover threshold input is driven to 2. The 36-bit address reaches a 0x8_0000_0000 read beyond any window, and a 4 GB node base shifts the window away from address zero. The 26-bit granule places the window edge exactly at 0x3FFF_FFFF/0x4000_0000 for a field of 0x0F. A threshold of 2 makes both the non-triggering and the triggering error observable, and an 8-bit field with a small installed size drives the size floor.

// File: rtl/mirr_pkg.sv
package mirr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRI,
      ST_PRI_W,
      ST_SEC,
      ST_SEC_W,
      ST_DONE
   } mirr_state_e;
endpackage

// File: rtl/mirr_range_cmp.sv
module mirr_range_cmp #(
   parameter int ADDR_W     = 40,
   parameter int GRAN_SHIFT = 26,
   parameter int FIELD_W    = 8
) (
   input  logic               en,
   input  logic [ADDR_W-1:0]  base,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [FIELD_W-1:0] field,
   output logic               hit
);
   localparam int EXT_W = ADDR_W + 1;
   localparam logic [EXT_W-1:0] ONE = EXT_W'(1);

   logic [EXT_W-1:0] span_bytes;
   logic [EXT_W-1:0] limit;

   always_comb begin
      span_bytes = (EXT_W'(field) + ONE) << GRAN_SHIFT;
      limit      = {1'b0, base} + span_bytes;
      hit        = en && (addr >= base) && ({1'b0, addr} < limit);
   end
endmodule

// File: rtl/mirr_fail_tracker.sv
module mirr_fail_tracker #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scrub_en,
   input  logic [CNT_W-1:0] thresh,
   input  logic             uce_evt,
   output logic             failed,
   output logic             fo_pulse
);
   localparam logic [CNT_W:0] INC = (CNT_W+1)'(1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] thr_eff;
   logic [CNT_W:0]   nxt;

   always_comb begin
      thr_eff = (thresh == '0) ? CNT_W'(1) : thresh;
      nxt     = {1'b0, cnt} + INC;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt      <= '0;
         failed   <= 1'b0;
         fo_pulse <= 1'b0;
      end else begin
         fo_pulse <= 1'b0;
         if (!scrub_en) begin
            cnt <= '0;
         end else if (uce_evt && !failed) begin
            cnt <= nxt[CNT_W] ? cnt : nxt[CNT_W-1:0];
            if (nxt >= {1'b0, thr_eff}) begin
               failed   <= 1'b1;
               fo_pulse <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/mirr_size_calc.sv
module mirr_size_calc #(
   parameter int SZ_W    = 15,
   parameter int FIELD_W = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic [FIELD_W-1:0] field,
   input  logic [SZ_W-1:0]    total,
   output logic [SZ_W-1:0]    usable
);
   localparam logic [SZ_W-1:0] ONE = SZ_W'(1);

   logic [SZ_W-1:0] span;
   logic [SZ_W-1:0] next_sz;

   always_comb begin
      span = SZ_W'(field) + ONE;
      if (!en)
         next_sz = total;
      else if (total > span)
         next_sz = total - span;
      else
         next_sz = '0;
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) usable <= '0;
            else        usable <= next_sz;
         end
      end else begin : g_comb
         assign usable = next_sz;
      end
   endgenerate
endmodule

// File: rtl/mirr_err_handler.sv
module mirr_err_handler
   import mirr_pkg::*;
#(
   parameter int ADDR_W     = 40,
   parameter int DATA_W     = 64,
   parameter int GRAN_SHIFT = 26,
   parameter int FIELD_W    = 8,
   parameter int CNT_W      = 4,
   parameter bit USABLE_REG = 1'b1,
   localparam int SZ_W      = ADDR_W - GRAN_SHIFT + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_mirror_en,
   input  logic [ADDR_W-1:0]  cfg_node_base,
   input  logic [FIELD_W-1:0] cfg_mirror_field,
   input  logic               cfg_scrub_en,
   input  logic [CNT_W-1:0]   cfg_fail_thresh,
   input  logic [SZ_W-1:0]    cfg_total_gran,
   input  logic               rd_valid,
   output logic               rd_ready,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic               rsp_valid,
   input  logic               rsp_ready,
   output logic [DATA_W-1:0]  rsp_data,
   output logic               rsp_poison,
   output logic               rsp_from_sec,
   output logic               mem_req_valid,
   output logic [ADDR_W-1:0]  mem_req_addr,
   output logic               mem_req_sec,
   input  logic               mem_rsp_valid,
   input  logic               mem_rsp_uce,
   input  logic [DATA_W-1:0]  mem_rsp_data,
   input  logic               wr_valid,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic               mem_wr_pri_valid,
   output logic               mem_wr_sec_valid,
   output logic [ADDR_W-1:0]  mem_wr_addr,
   output logic [DATA_W-1:0]  mem_wr_data,
   output logic               ce_pulse,
   output logic               mce_pulse,
   output logic               failover_pulse,
   output logic               failover_state,
   output logic [SZ_W-1:0]    usable_size
);
   generate
      if (GRAN_SHIFT < 1 || GRAN_SHIFT >= ADDR_W) begin : g_bad_gran
         $error("GRAN_SHIFT must lie in 1..ADDR_W-1");
      end
      if (FIELD_W > ADDR_W - GRAN_SHIFT) begin : g_bad_field
         $error("FIELD_W must not exceed the granule index width");
      end
      if (CNT_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("CNT_W and DATA_W must be positive");
      end
   endgenerate

   mirr_state_e        state;
   logic [ADDR_W-1:0]  addr_q;
   logic               hit_q;
   logic [DATA_W-1:0]  data_q;
   logic               poison_q;
   logic               sec_q;
   logic               ce_q;
   logic               mce_q;
   logic               rd_hit;
   logic               wr_hit;
   logic               failed;
   logic               uce_evt;

   mirr_range_cmp #(.ADDR_W(ADDR_W), .GRAN_SHIFT(GRAN_SHIFT), .FIELD_W(FIELD_W)) u_rd_cmp (
      .en(cfg_mirror_en), .base(cfg_node_base), .addr(rd_addr),
      .field(cfg_mirror_field), .hit(rd_hit)
   );

   mirr_range_cmp #(.ADDR_W(ADDR_W), .GRAN_SHIFT(GRAN_SHIFT), .FIELD_W(FIELD_W)) u_wr_cmp (
      .en(cfg_mirror_en), .base(cfg_node_base), .addr(wr_addr),
      .field(cfg_mirror_field), .hit(wr_hit)
   );

   assign uce_evt = (state == ST_PRI_W) && mem_rsp_valid && mem_rsp_uce && hit_q && !failed;

   mirr_fail_tracker #(.CNT_W(CNT_W)) u_track (
      .clk(clk), .rst_n(rst_n), .scrub_en(cfg_scrub_en), .thresh(cfg_fail_thresh),
      .uce_evt(uce_evt), .failed(failed), .fo_pulse(failover_pulse)
   );

   mirr_size_calc #(.SZ_W(SZ_W), .FIELD_W(FIELD_W), .REG_OUT(USABLE_REG)) u_size (
      .clk(clk), .rst_n(rst_n), .en(cfg_mirror_en), .field(cfg_mirror_field),
      .total(cfg_total_gran), .usable(usable_size)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         addr_q   <= '0;
         hit_q    <= 1'b0;
         data_q   <= '0;
         poison_q <= 1'b0;
         sec_q    <= 1'b0;
         ce_q     <= 1'b0;
         mce_q    <= 1'b0;
      end else begin
         ce_q  <= 1'b0;
         mce_q <= 1'b0;
         case (state)
            ST_IDLE: if (rd_valid) begin
               addr_q <= rd_addr;
               hit_q  <= rd_hit;
               state  <= ST_PRI;
            end
            ST_PRI: state <= ST_PRI_W;
            ST_PRI_W: if (mem_rsp_valid) begin
               if (!mem_rsp_uce) begin
                  data_q   <= mem_rsp_data;
                  poison_q <= 1'b0;
                  sec_q    <= 1'b0;
                  state    <= ST_DONE;
               end else if (hit_q && !failed) begin
                  state <= ST_SEC;
               end else begin
                  data_q   <= mem_rsp_data;
                  poison_q <= 1'b1;
                  sec_q    <= 1'b0;
                  mce_q    <= 1'b1;
                  state    <= ST_DONE;
               end
            end
            ST_SEC: state <= ST_SEC_W;
            ST_SEC_W: if (mem_rsp_valid) begin
               data_q   <= mem_rsp_data;
               sec_q    <= 1'b1;
               poison_q <= mem_rsp_uce;
               mce_q    <= mem_rsp_uce;
               ce_q     <= !mem_rsp_uce;
               state    <= ST_DONE;
            end
            ST_DONE: if (rsp_ready) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      rd_ready         = (state == ST_IDLE);
      mem_req_valid    = (state == ST_PRI) || (state == ST_SEC);
      mem_req_sec      = (state == ST_SEC);
      mem_req_addr     = addr_q;
      rsp_valid        = (state == ST_DONE);
      rsp_data         = data_q;
      rsp_poison       = poison_q;
      rsp_from_sec     = sec_q;
      ce_pulse         = ce_q;
      mce_pulse        = mce_q;
      failover_state   = failed;
      mem_wr_pri_valid = wr_valid;
      mem_wr_sec_valid = wr_valid && wr_hit && !failed;
      mem_wr_addr      = wr_addr;
      mem_wr_data      = wr_data;
   end
endmodule

// File: rtl/mirr_err_handler_chk.sv
module mirr_err_handler_chk #(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_scrub_en,
   input logic              rd_ready,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic [DATA_W-1:0] rsp_data,
   input logic              rsp_poison,
   input logic              mem_req_valid,
   input logic              mem_wr_pri_valid,
   input logic              mem_wr_sec_valid,
   input logic              ce_pulse,
   input logic              mce_pulse,
   input logic              failover_pulse,
   input logic              failover_state
);
   // R5
   ce_mce_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ce_pulse && mce_pulse));

   // R6
   fo_sets_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      failover_pulse |=> failover_state);

   // R6
   fo_no_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(failover_state));

   // R7
   fo_needs_scrub_chk: assert property (@(posedge clk) disable iff (!rst_n)
      failover_pulse |-> $past(cfg_scrub_en));

   // R9
   wr_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_sec_valid |-> (mem_wr_pri_valid && !failover_state));

   // R11
   req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !rd_ready);

   // R12
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_poison)));
endmodule

bind mirr_err_handler mirr_err_handler_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/mirr_err_handler_tb_top.sv
module mirr_err_handler_tb_top;
   localparam int ADDR_W = 36;
   localparam int DATA_W = 64;
   localparam int GS     = 26;
   localparam int FW     = 8;
   localparam int CW     = 4;
   localparam int SZ_W   = ADDR_W - GS + 1;
   localparam int VW     = 42;

   // {addr, pri_uce, sec_uce, exp_ce, exp_mce, exp_from_sec, exp_poison}
   localparam logic [VW-1:0] VEC [0:7] = '{
      {36'h0_0000_1000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {36'h0_0000_1000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
      {36'h0_3FFF_FFFE, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
      {36'h0_4000_0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
      {36'h0_4000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {36'h0_2000_0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
      {36'h8_0000_0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
      {36'h0_3FFF_FFC0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_mirror_en = 1'b1;
   logic [ADDR_W-1:0] cfg_node_base = '0;
   logic [FW-1:0] cfg_mirror_field = 8'h0F;
   logic cfg_scrub_en = 1'b0;
   logic [CW-1:0] cfg_fail_thresh = 4'd2;
   logic [SZ_W-1:0] cfg_total_gran = 11'd512;
   logic rd_valid = 1'b0;
   logic rd_ready;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic rsp_valid;
   logic rsp_ready = 1'b1;
   logic [DATA_W-1:0] rsp_data;
   logic rsp_poison, rsp_from_sec;
   logic mem_req_valid, mem_req_sec;
   logic [ADDR_W-1:0] mem_req_addr;
   logic mem_rsp_valid = 1'b0;
   logic mem_rsp_uce = 1'b0;
   logic [DATA_W-1:0] mem_rsp_data = '0;
   logic wr_valid = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic mem_wr_pri_valid, mem_wr_sec_valid;
   logic [ADDR_W-1:0] mem_wr_addr;
   logic [DATA_W-1:0] mem_wr_data;
   logic ce_pulse, mce_pulse, failover_pulse, failover_state;
   logic [SZ_W-1:0] usable_size;

   int errs = 0;
   int checks = 0;
   int ce_cnt = 0, mce_cnt = 0, fo_cnt = 0, sec_cnt = 0;
   logic inj_pri = 1'b0, inj_sec = 1'b0;

   always #5 clk = ~clk;

   mirr_err_handler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GRAN_SHIFT(GS), .FIELD_W(FW),
                      .CNT_W(CW), .USABLE_REG(1'b1)) dut_i (.*);

   function automatic logic [DATA_W-1:0] fpri(input logic [ADDR_W-1:0] a);
      return {28'h0, a} ^ 64'h0123_4567_89AB_CDEF;
   endfunction
   function automatic logic [DATA_W-1:0] fsec(input logic [ADDR_W-1:0] a);
      return fpri(a) ^ 64'hFFFF_0000_FFFF_0000;
   endfunction

   always @(posedge clk) begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid) begin
         mem_rsp_valid <= 1'b1;
         mem_rsp_uce   <= mem_req_sec ? inj_sec : inj_pri;
         mem_rsp_data  <= mem_req_sec ? fsec(mem_req_addr) : fpri(mem_req_addr);
      end
      if (ce_pulse) ce_cnt <= ce_cnt + 1;
      if (mce_pulse) mce_cnt <= mce_cnt + 1;
      if (failover_pulse) fo_cnt <= fo_cnt + 1;
      if (mem_req_valid && mem_req_sec) sec_cnt <= sec_cnt + 1;
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_read(input logic [ADDR_W-1:0] a, input logic pu, input logic su,
                          output logic [DATA_W-1:0] d, output logic pois, output logic fs,
                          output int dce, output int dmce, output int dfo, output int dsec);
      int c0, m0, f0, s0, t;
      c0 = ce_cnt; m0 = mce_cnt; f0 = fo_cnt; s0 = sec_cnt; t = 0;
      inj_pri = pu; inj_sec = su;
      @(negedge clk); rd_addr = a; rd_valid = 1'b1;
      @(negedge clk); rd_valid = 1'b0;
      while (!rsp_valid && t < 50) begin @(negedge clk); t++; end
      chk(rsp_valid, "R11 response arrives", {63'h0, rsp_valid}, 64'h1);
      d = rsp_data; pois = rsp_poison; fs = rsp_from_sec;
      @(negedge clk); @(negedge clk);
      dce = ce_cnt - c0; dmce = mce_cnt - m0; dfo = fo_cnt - f0; dsec = sec_cnt - s0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #1ms;
      errs++; checks++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic [DATA_W-1:0] d, d0;
      logic pois, fs;
      int dce, dmce, dfo, dsec;

      do_reset();
      // R11 reset state
      chk(rd_ready && !rsp_valid && !mem_req_valid, "R11 idle after reset",
          {61'h0, rd_ready, rsp_valid, mem_req_valid}, 64'h4);
      chk(!ce_pulse && !mce_pulse && !failover_pulse && !failover_state, "R11 no events after reset",
          {60'h0, ce_pulse, mce_pulse, failover_pulse, failover_state}, 64'h0);
      // R10 size with 16 granules mirrored
      chk(usable_size == 11'd496, "R10 usable size", 64'(usable_size), 64'd496);

      // Table walk: R1..R5, scrub off so R7 counting is idle
      for (int i = 0; i < 8; i++) begin
         logic [ADDR_W-1:0] a;
         logic [DATA_W-1:0] ed;
         a = VEC[i][41:6];
         do_read(a, VEC[i][5], VEC[i][4], d, pois, fs, dce, dmce, dfo, dsec);
         ed = VEC[i][1] ? fsec(a) : fpri(a);
         chk(d == ed, "R2 R3 response data", d, ed);
         chk(pois == VEC[i][0], "R4 R5 poison flag", 64'(pois), 64'(VEC[i][0]));
         chk(fs == VEC[i][1], "R3 copy selected", 64'(fs), 64'(VEC[i][1]));
         chk(dce == int'(VEC[i][3]), "R3 corrected pulses", 64'(dce), 64'(VEC[i][3]));
         chk(dmce == int'(VEC[i][2]), "R4 fatal pulses", 64'(dmce), 64'(VEC[i][2]));
         chk(dsec == int'(VEC[i][5] && VEC[i][1]), "R1 secondary reads", 64'(dsec),
             64'(VEC[i][5] && VEC[i][1]));
         chk(dfo == 0, "R7 no failover with scrub off", 64'(dfo), 64'd0);
      end
      chk(!failover_state, "R7 state stays clear", 64'(failover_state), 64'd0);

      // R10 disabled and floor
      cfg_mirror_en = 1'b0;
      @(negedge clk); @(negedge clk);
      chk(usable_size == 11'd512, "R10 size unmirrored", 64'(usable_size), 64'd512);
      cfg_mirror_en = 1'b1; cfg_mirror_field = 8'hFF; cfg_total_gran = 11'd200;
      @(negedge clk); @(negedge clk);
      chk(usable_size == 11'd0, "R10 size floor", 64'(usable_size), 64'd0);
      cfg_mirror_field = 8'h0F; cfg_total_gran = 11'd512;

      // R1 node base shift to 4 GB
      cfg_node_base = 36'h1_0000_0000;
      do_read(36'h0_0000_1000, 1'b1, 1'b0, d, pois, fs, dce, dmce, dfo, dsec);
      chk(dmce == 1 && dce == 0 && pois, "R1 below base unmirrored", 64'(dmce), 64'd1);
      do_read(36'h1_3FFF_FFFF, 1'b1, 1'b0, d, pois, fs, dce, dmce, dfo, dsec);
      chk(dce == 1 && fs && !pois, "R1 last byte above base mirrored", 64'(dce), 64'd1);
      chk(d == fsec(36'h1_3FFF_FFFF), "R3 secondary data", d, fsec(36'h1_3FFF_FFFF));
      cfg_node_base = '0;
      cfg_mirror_en = 1'b0;
      do_read(36'h0_0000_1000, 1'b1, 1'b0, d, pois, fs, dce, dmce, dfo, dsec);
      chk(dmce == 1 && dsec == 0, "R1 disabled window is fatal", 64'(dmce), 64'd1);
      cfg_mirror_en = 1'b1;

      // R9 write duplication
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = 36'h0_1000_0040; wr_data = 64'hDEAD_BEEF_0000_1111;
      #1;
      chk(mem_wr_pri_valid && mem_wr_sec_valid, "R9 mirrored write duplicated",
          {62'h0, mem_wr_pri_valid, mem_wr_sec_valid}, 64'h3);
      chk(mem_wr_addr == wr_addr && mem_wr_data == wr_data, "R9 write passthrough",
          mem_wr_data, wr_data);
      wr_addr = 36'h0_4000_0000;
      #1;
      chk(mem_wr_pri_valid && !mem_wr_sec_valid, "R9 unmirrored write single",
          {62'h0, mem_wr_pri_valid, mem_wr_sec_valid}, 64'h2);
      @(negedge clk); wr_valid = 1'b0;

      // R12 response hold
      inj_pri = 1'b0; rsp_ready = 1'b0;
      @(negedge clk); rd_addr = 36'h0_0200_0000; rd_valid = 1'b1;
      @(negedge clk); rd_valid = 1'b0;
      repeat (6) @(negedge clk);
      d0 = rsp_data;
      repeat (3) @(negedge clk);
      chk(rsp_valid && rsp_data == d0, "R12 response held", rsp_data, d0);
      chk(d0 == fpri(36'h0_0200_0000), "R2 held data", d0, fpri(36'h0_0200_0000));
      rsp_ready = 1'b1;
      @(negedge clk);
      chk(!rsp_valid && rd_ready, "R12 released after ready", 64'(rsp_valid), 64'd0);

      // R6 failover with scrub on, threshold 2
      cfg_scrub_en = 1'b1;
      do_read(36'h0_0000_2000, 1'b1, 1'b0, d, pois, fs, dce, dmce, dfo, dsec);
      chk(dce == 1 && dfo == 0 && !failover_state, "R7 earlier errors not counted",
          64'(dfo), 64'd0);
      do_read(36'h0_0000_3000, 1'b1, 1'b0, d, pois, fs, dce, dmce, dfo, dsec);
      chk(dfo == 1 && failover_state, "R6 failover declared", 64'(dfo), 64'd1);
      chk(dce == 1 && dmce == 0 && fs && d == fsec(36'h0_0000_3000), "R6 trigger read recovered",
          d, fsec(36'h0_0000_3000));

      // R8 independent mode after failover
      do_read(36'h0_0000_4000, 1'b1, 1'b0, d, pois, fs, dce, dmce, dfo, dsec);
      chk(dmce == 1 && dce == 0 && pois && dsec == 0, "R8 fatal after failover",
          64'(dmce), 64'd1);
      chk(dfo == 0, "R6 single failover pulse", 64'(dfo), 64'd0);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = 36'h0_0000_4000;
      #1;
      chk(mem_wr_pri_valid && !mem_wr_sec_valid, "R9 no duplicate after failover",
          64'(mem_wr_sec_valid), 64'd0);
      @(negedge clk); wr_valid = 1'b0;
      repeat (5) @(negedge clk);
      chk(failover_state, "R6 failover sticky", 64'(failover_state), 64'd1);

      do_reset();
      chk(!failover_state, "R6 cleared by reset", 64'(failover_state), 64'd0);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule